// File: doc/BRIEF.md
# Dual-Structure 16-bit Pseudo-Random Sequence Generator

This block produces a maximal-length pseudo-random bit stream from a 16-bit shift register. A static mode input selects whether feedback is formed as one parity sum that enters the top stage (external XOR), or is spread as a toggle mask across the tapped stages (internal XOR). Both structures use fixed, mirrored tap sets, so each walks all 65,535 nonzero states before it repeats. The register advances one state on every clock with the step enable high. The serial bit and the whole parallel state are visible on every cycle.

A seed port writes the start state and also stores it as the reference for wrap detection. A zero seed is replaced by 0x0001, so the register can never reach the all-zero lock-up state. A one-cycle wrap pulse marks the step that brings the register back to the stored seed, which lets a consumer count whole periods or frame a sequence.

Top module: `lfsr_dual_gen`

## Requirements
- R1: After reset the state is 0xACE1, the stored seed is 0xACE1 and wrap_pulse is low.
- R2: With mode_sel = 0 (external XOR), a step moves state bits 15..1 into bits 14..0, and the new bit 15 is the XOR of state bits 0, 2, 3 and 5 (mask 0x002D).
- R3: With mode_sel = 1 (internal XOR), a step shifts the state right by one, then XORs it with 0xB400 when the old bit 0 was 1.
- R4: bit_out always equals bit 0 of state_out.
- R5: With step_en low and seed_load low, the state does not change.
- R6: With seed_load high, the next state and the stored seed both take seed_val. This takes priority over a step in the same cycle.
- R7: A seed_val of 0x0000 is loaded as 0x0001.
- R8: wrap_pulse is high for exactly the one cycle after a step whose new state equals the stored seed. It is low in every other case, including any cycle that follows a load.
- R9: In either mode, from a nonzero seed, the state first returns to the seed after exactly 65,535 steps and is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 1 | 0 = external-XOR feedback, 1 = internal-XOR feedback; held static while running |
| step_en | input | 1 | Advance one state this cycle |
| seed_load | input | 1 | Load seed_val as state and as the stored seed |
| seed_val | input | 16 | Seed value; zero is replaced by 0x0001 |
| bit_out | output | 1 | Serial output, bit 0 of the state |
| state_out | output | 16 | Current register state |
| wrap_pulse | output | 1 | One-cycle flag: the state has returned to the stored seed |

## Verification
A seed load and a step can arrive in the same cycle. The most telling case is the step that would bring the register back to its seed, where that step would also raise the wrap flag. The bench runs the internal-XOR mode for a full period and raises seed_load with a fresh value together with the final step. It then expects the loaded value in the state and wrap_pulse low. The external-XOR run, with no load, confirms that the pulse appears on the 65,535th step and on no earlier one.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  localparam int unsigned LFSR_W = 16;

  typedef enum logic {
    FB_EXTERNAL = 1'b0,
    FB_INTERNAL = 1'b1
  } fb_mode_e;
endpackage

// File: rtl/lfsr_rst_sync.sv
module lfsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ok = chain_q[STAGES-1];
endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] safe
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    if (raw == '0) safe = ONE;
    else           safe = raw;
  end
endmodule

// File: rtl/lfsr_step.sv
module lfsr_step #(
  parameter int unsigned   W        = 16,
  parameter logic [W-1:0]  EXT_MASK = 16'h002D,
  parameter logic [W-1:0]  INT_MASK = 16'hB400
) (
  input  logic [W-1:0] cur,
  input  logic         internal_mode,
  output logic [W-1:0] nxt
);
  logic [W-1:0] ext_nxt;
  logic [W-1:0] int_nxt;
  logic         out_bit;

  assign out_bit = cur[0];

  // external XOR: one parity term enters the top stage
  assign ext_nxt = {^(cur & EXT_MASK), cur[W-1:1]};

  // internal XOR: each tapped stage toggles with the output bit
  genvar g;
  generate
    for (g = 0; g < W - 1; g++) begin : g_int
      assign int_nxt[g] = cur[g+1] ^ (out_bit & INT_MASK[g]);
    end
  endgenerate
  assign int_nxt[W-1] = out_bit & INT_MASK[W-1];

  always_comb begin
    if (internal_mode) nxt = int_nxt;
    else               nxt = ext_nxt;
  end
endmodule

// File: rtl/lfsr_dual_gen.sv
module lfsr_dual_gen #(
  parameter int unsigned                   WIDTH    = lfsr_pkg::LFSR_W,
  parameter logic [WIDTH-1:0]              EXT_MASK = 16'h002D,
  parameter logic [WIDTH-1:0]              INT_MASK = 16'hB400,
  parameter logic [WIDTH-1:0]              RST_SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             step_en,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed_val,
  output logic             bit_out,
  output logic [WIDTH-1:0] state_out,
  output logic             wrap_pulse
);
  import lfsr_pkg::*;

  logic             rst_ok;
  fb_mode_e         mode;
  logic [WIDTH-1:0] state_q, state_d;
  logic [WIDTH-1:0] seed_q, seed_d;
  logic             wrap_q, wrap_d;
  logic [WIDTH-1:0] step_nxt;
  logic [WIDTH-1:0] seed_safe;

  assign mode = fb_mode_e'(mode_sel);

  lfsr_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  lfsr_seed_guard #(.W(WIDTH)) u_guard (
    .raw  (seed_val),
    .safe (seed_safe)
  );

  lfsr_step #(.W(WIDTH), .EXT_MASK(EXT_MASK), .INT_MASK(INT_MASK)) u_step (
    .cur           (state_q),
    .internal_mode (mode == FB_INTERNAL),
    .nxt           (step_nxt)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    seed_d  = seed_q;
    wrap_d  = 1'b0;
    if (seed_load) begin
      state_d = seed_safe;
      seed_d  = seed_safe;
    end else if (step_en) begin
      state_d = step_nxt;
      wrap_d  = (step_nxt == seed_q);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      state_q <= RST_SEED;
      seed_q  <= RST_SEED;
      wrap_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      seed_q  <= seed_d;
      wrap_q  <= wrap_d;
    end
  end

  assign state_out  = state_q;
  assign bit_out    = state_q[0];
  assign wrap_pulse = wrap_q;
endmodule

// File: rtl/lfsr_dual_gen_chk.sv
module lfsr_dual_gen_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         mode_sel,
  input logic         step_en,
  input logic         seed_load,
  input logic [W-1:0] seed_val,
  input logic         bit_out,
  input logic [W-1:0] state_out,
  input logic [W-1:0] seed_q,
  input logic         wrap_pulse
);
  a_r9_never_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    state_out != '0);

  a_r4_serial_bit: assert property (@(posedge clk) disable iff (!rst_ok)
    bit_out == state_out[0]);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (!step_en && !seed_load) |=> $stable(state_out));

  a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_ok)
    (seed_load && seed_val != '0) |=> (state_out == $past(seed_val) && seed_q == $past(seed_val)));

  a_r7_zero_seed: assert property (@(posedge clk) disable iff (!rst_ok)
    (seed_load && seed_val == '0) |=> (state_out == {{(W-1){1'b0}}, 1'b1}));

  a_r2_ext_shift: assert property (@(posedge clk) disable iff (!rst_ok)
    (step_en && !seed_load && !mode_sel) |=> (state_out[W-2:0] == $past(state_out[W-1:1])));

  a_r3_int_top: assert property (@(posedge clk) disable iff (!rst_ok)
    (step_en && !seed_load && mode_sel) |=> (state_out[W-1] == $past(state_out[0])));

  a_r8_wrap_at_seed: assert property (@(posedge clk) disable iff (!rst_ok)
    wrap_pulse |-> (state_out == seed_q));

  a_r8_wrap_single: assert property (@(posedge clk) disable iff (!rst_ok)
    wrap_pulse |=> !wrap_pulse);

  a_r8_load_clears: assert property (@(posedge clk) disable iff (!rst_ok)
    seed_load |=> !wrap_pulse);
endmodule

bind lfsr_dual_gen lfsr_dual_gen_chk #(.W(WIDTH)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_ok),
  .mode_sel   (mode_sel),
  .step_en    (step_en),
  .seed_load  (seed_load),
  .seed_val   (seed_val),
  .bit_out    (bit_out),
  .state_out  (state_out),
  .seed_q     (seed_q),
  .wrap_pulse (wrap_pulse)
);

// File: tb/lfsr_dual_gen_test.sv
`timescale 1ns/1ps
module lfsr_dual_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_sel;
  logic        step_en;
  logic        seed_load;
  logic [15:0] seed_val;
  logic        bit_out;
  logic [15:0] state_out;
  logic        wrap_pulse;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  lfsr_dual_gen uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .step_en    (step_en),
    .seed_load  (seed_load),
    .seed_val   (seed_val),
    .bit_out    (bit_out),
    .state_out  (state_out),
    .wrap_pulse (wrap_pulse)
  );

  // expected steps, from the requirement text
  function automatic logic [15:0] ext_model(input logic [15:0] s);
    logic fb;
    fb = s[0] ^ s[2] ^ s[3] ^ s[5];
    return (s >> 1) | (16'(fb) << 15);
  endfunction

  function automatic logic [15:0] int_model(input logic [15:0] s);
    logic [15:0] r;
    r = s >> 1;
    if (s[0]) r = r ^ 16'hB400;
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // run N steps, checking each; returns index of first wrap
  task automatic run_steps(input string req, input bit internal, input int unsigned count,
                           input logic [15:0] seed_m, inout logic [15:0] model,
                           output int unsigned first_wrap);
    first_wrap = 0;
    step_en = 1'b1;
    for (int unsigned k = 1; k <= count; k++) begin
      @(negedge clk);
      model = internal ? int_model(model) : ext_model(model);
      check(req, state_out, model);
      check("R4", 16'(bit_out), 16'(model[0]));
      check("R8", 16'(wrap_pulse), 16'(model == seed_m));
      if (wrap_pulse && first_wrap == 0) first_wrap = k;
    end
    step_en = 1'b0;
  endtask

  initial begin
    logic [15:0] model;
    logic [15:0] seed_m;
    int unsigned fw;
    rst_n = 1'b0; mode_sel = 1'b0; step_en = 1'b0; seed_load = 1'b0; seed_val = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1", state_out, 16'hACE1);
    check("R1", 16'(wrap_pulse), 16'h0);
    check("R4", 16'(bit_out), 16'h1);
    model = 16'hACE1; seed_m = 16'hACE1;

    // R5 hold with enable low
    repeat (5) @(negedge clk);
    check("R5", state_out, model);

    // R2/R9 full external-XOR period
    run_steps("R2", 1'b0, 65535, seed_m, model, fw);
    check("R9", 16'(fw), 16'(65535 % 65536));
    check("R9", state_out, seed_m);

    // R8 pulse lasts one cycle: one more step
    run_steps("R2", 1'b0, 1, seed_m, model, fw);
    check("R8", 16'(wrap_pulse), 16'h0);

    // R7 zero seed, R6 load
    seed_load = 1'b1; seed_val = 16'h0000;
    @(negedge clk);
    seed_load = 1'b0;
    model = 16'h0001; seed_m = 16'h0001;
    check("R7", state_out, 16'h0001);
    check("R8", 16'(wrap_pulse), 16'h0);

    // R3 internal-XOR period; collision on the final step
    mode_sel = 1'b1;
    run_steps("R3", 1'b1, 65534, seed_m, model, fw);
    check("R9", 16'(fw), 16'h0);
    check("R3", int_model(model), seed_m);   // the next step would wrap
    step_en = 1'b1; seed_load = 1'b1; seed_val = 16'h1234;
    @(negedge clk);
    step_en = 1'b0; seed_load = 1'b0;
    model = 16'h1234; seed_m = 16'h1234;
    check("R6", state_out, 16'h1234);
    check("R8", 16'(wrap_pulse), 16'h0);

    // R3 a few internal steps from the new seed
    run_steps("R3", 1'b1, 20, seed_m, model, fw);

    // R6 load with enable low, external mode, then steps
    mode_sel = 1'b0;
    seed_load = 1'b1; seed_val = 16'h8000;
    @(negedge clk);
    seed_load = 1'b0;
    model = 16'h8000; seed_m = 16'h8000;
    check("R6", state_out, 16'h8000);
    check("R4", 16'(bit_out), 16'h0);
    run_steps("R2", 1'b0, 20, seed_m, model, fw);
    repeat (3) @(negedge clk);
    check("R5", state_out, model);

    done = 1'b1;
    report();
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end
endmodule